// File: doc/BRIEF.md
# Dual-Side Mailbox Register Bank

This block is a small bank of byte-wide registers that two agents share: a host processor and a management controller. Each agent has its own single-cycle register port (write enable, address, write data, combinational read data). Through the bank the two sides exchange message bytes, post status flags, and ring doorbells at each other. The block gives no meaning to message content; software on both sides decides what the bytes say.

Both sides see the same 32-entry address window. Fourteen message bytes sit at the bottom of the window. Above them are a flag byte, two status bytes, one doorbell control byte per side and two interrupt-enable bytes per side. Each side has a level interrupt output. The host interrupt covers the host doorbell and any enabled status bit. The management interrupt covers the management doorbell. Pending bits are cleared by writing a one to them.

Top module: `dual_mailbox_regs`

## Requirements
- R1: After a synchronous active-low reset, every offset reads 0x00 from both ports and both interrupt outputs are low.
- R2: Offsets 0x00 to 0x0D hold message bytes. Either side may write them and both sides read the stored value. On a same-cycle write to the same offset, the management value is stored.
- R3: Offset 0x0F is a flag byte written only by the management side. Bit 0 means the controller restarted and bit 1 means an operation finished. Host writes to it have no effect.
- R4: Offsets 0x10 and 0x11 are status bytes. A management write sets every bit written as 1. A host write clears every bit written as 1. If both happen on the same bit in the same cycle, the bit is set. Bit 7 of 0x11 is the attention bit.
- R5: A host write to 0x13 with bit 0 set raises bit 7 of 0x12. A management write to 0x12 with bit 0 set raises bit 7 of 0x13.
- R6: The owning side (management for 0x12, host for 0x13) clears bit 7 of its control byte by writing it as 1. A ring from the other side in the same cycle wins. Writes to the other side's control byte do not change it.
- R7: Bit 1 of each control byte is a mask stored from every write by its owning side. Bit 0 and bits 6..2 always read 0.
- R8: Offsets 0x14/0x15 are management enables and are written only by the management side. Offsets 0x16/0x17 are host enables and are written only by the host. All four read back from both ports.
- R9: The host interrupt is high exactly when (bit 7 of 0x13 is set and bit 1 of 0x13 is clear), or when some bit i of 0x10 and bit i of 0x16 are both set, or when some bit i of 0x11 and bit i of 0x17 are both set.
- R10: The management interrupt is high exactly when bit 7 of 0x12 is set and bit 1 of 0x12 is clear.
- R11: Offsets 0x0E and 0x18 to 0x1F read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 5 | Host register offset |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (combinational) |
| m_we | input | 1 | Management write strobe |
| m_addr | input | 5 | Management register offset |
| m_wdata | input | 8 | Management write byte |
| m_rdata | output | 8 | Management read byte (combinational) |
| h_irq | output | 1 | Host level interrupt |
| m_irq | output | 1 | Management level interrupt |

## Verification
The assertions assume that each write strobe is a clean one-cycle level, sampled at the rising edge together with a stable address and data. They also assume that a doorbell clear can only be predicted when no ring arrives from the other side in the same cycle, so the clear property names that exclusion. The bench keeps to these assumptions by changing inputs only on the falling edge and dropping the strobes right after each edge. It also drives same-cycle collisions on purpose, so that the set-wins and management-wins orderings are exercised.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the dual-side mailbox bank.
// Assumes a byte-wide bank in a 32-entry window; offsets that neighbours
// decode are fixed here.
package mbx_pkg;
    localparam int ADDR_W     = 5;
    localparam int BYTE_W     = 8;
    localparam int MSG_BYTES  = 14;
    localparam int STAT_BYTES = 2;
    localparam int STAT_W     = STAT_BYTES * BYTE_W;
    localparam int WIN_SIZE   = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] OFF_FLAG  = 5'h0F;
    localparam logic [ADDR_W-1:0] OFF_STAT0 = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_MCTL  = 5'h12;
    localparam logic [ADDR_W-1:0] OFF_HCTL  = 5'h13;
    localparam logic [ADDR_W-1:0] OFF_MEN0  = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_HEN0  = 5'h16;

    localparam int CTL_PEND = 7;
    localparam int CTL_MASK = 1;
    localparam int CTL_SEND = 0;
    localparam int ATTN_BIT = BYTE_W + 7;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/mbx_msg_bank.sv
`timescale 1ns/1ps
// Message byte storage plus the management-owned flag byte.
// Assumes: both ports may write message bytes; management wins a collision.
module mbx_msg_bank
    import mbx_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  wr_req_t                           host_wr,
    input  wr_req_t                           mgmt_wr,
    output logic [MSG_BYTES-1:0][BYTE_W-1:0]  msg_q,
    output logic [BYTE_W-1:0]                 flag_q
);
    for (genvar i = 0; i < MSG_BYTES; i++) begin : g_msg
        logic [BYTE_W-1:0] byte_q;
        logic              m_hit, h_hit;
        assign m_hit = mgmt_wr.we && (mgmt_wr.addr == ADDR_W'(i));
        assign h_hit = host_wr.we && (host_wr.addr == ADDR_W'(i));

        // Store one message byte, management side taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)     byte_q <= '0;
            else if (m_hit) byte_q <= mgmt_wr.data;
            else if (h_hit) byte_q <= host_wr.data;
        end
        assign msg_q[i] = byte_q;
    end

    // Flag byte: written by the management side only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (mgmt_wr.we && mgmt_wr.addr == OFF_FLAG)
            flag_q <= mgmt_wr.data;
    end
endmodule

// File: rtl/mbx_status_bank.sv
`timescale 1ns/1ps
// Status bytes (management sets, host clears by writing ones) and the
// per-side interrupt enable bytes. Assumes a set beats a same-cycle clear.
module mbx_status_bank
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           host_wr,
    input  wr_req_t           mgmt_wr,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] m_en_q,
    output logic [STAT_W-1:0] h_en_q
);
    for (genvar j = 0; j < STAT_BYTES; j++) begin : g_stat
        logic [BYTE_W-1:0] st_q, men_q, hen_q;
        logic [BYTE_W-1:0] set_bits, clr_bits;

        assign set_bits = (mgmt_wr.we && mgmt_wr.addr == OFF_STAT0 + ADDR_W'(j))
                          ? mgmt_wr.data : '0;
        assign clr_bits = (host_wr.we && host_wr.addr == OFF_STAT0 + ADDR_W'(j))
                          ? host_wr.data : '0;

        // Status byte update: clear by host ones, then set by management ones.
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= (st_q & ~clr_bits) | set_bits;
        end

        // Management enable byte, owned by the management side.
        always_ff @(posedge clk) begin
            if (!rst_n)
                men_q <= '0;
            else if (mgmt_wr.we && mgmt_wr.addr == OFF_MEN0 + ADDR_W'(j))
                men_q <= mgmt_wr.data;
        end

        // Host enable byte, owned by the host side.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hen_q <= '0;
            else if (host_wr.we && host_wr.addr == OFF_HEN0 + ADDR_W'(j))
                hen_q <= host_wr.data;
        end

        assign stat_q[j*BYTE_W +: BYTE_W] = st_q;
        assign m_en_q[j*BYTE_W +: BYTE_W] = men_q;
        assign h_en_q[j*BYTE_W +: BYTE_W] = hen_q;
    end
endmodule

// File: rtl/mbx_doorbell.sv
`timescale 1ns/1ps
// One side's doorbell control byte: a pending bit rung by the peer and
// cleared by the owner writing a one, plus an owner-written mask bit.
// Assumes the decode of owner and peer writes is done by the parent.
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_wr_i,
    input  logic              own_clr_i,
    input  logic              own_mask_i,
    input  logic              ring_i,
    output logic [BYTE_W-1:0] ctl_o,
    output logic              irq_o
);
    logic pend_q, mask_q;

    // Pending bit: ring from the peer wins over the owner's clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pend_q <= 1'b0;
        else if (ring_i)                pend_q <= 1'b1;
        else if (own_wr_i && own_clr_i) pend_q <= 1'b0;
    end

    // Mask bit: taken from every owner write.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= 1'b0;
        else if (own_wr_i) mask_q <= own_mask_i;
    end

    // Read view: send and reserved bits always read zero.
    always_comb begin
        ctl_o           = '0;
        ctl_o[CTL_PEND] = pend_q;
        ctl_o[CTL_MASK] = mask_q;
    end

    assign irq_o = pend_q & ~mask_q;
endmodule

// File: rtl/dual_mailbox_regs.sv
`timescale 1ns/1ps
// Top of the dual-side mailbox bank: two byte ports over a shared window,
// doorbells in both directions, status bits and level interrupts.
// Assumes single-cycle write strobes; reads are combinational.
module dual_mailbox_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [BYTE_W-1:0] h_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [BYTE_W-1:0] m_wdata,
    output logic [BYTE_W-1:0] m_rdata,
    output logic              h_irq,
    output logic              m_irq
);
    wr_req_t host_wr, mgmt_wr;
    assign host_wr = '{we: h_we, addr: h_addr, data: h_wdata};
    assign mgmt_wr = '{we: m_we, addr: m_addr, data: m_wdata};

    logic [MSG_BYTES-1:0][BYTE_W-1:0] msg_q;
    logic [BYTE_W-1:0]                flag_q;
    logic [STAT_W-1:0]                stat_q, m_en_q, h_en_q;
    logic [BYTE_W-1:0]                h_ctl_q, m_ctl_q;
    logic                             h_door_irq, m_door_irq;

    mbx_msg_bank u_msg (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .mgmt_wr(mgmt_wr),
        .msg_q(msg_q), .flag_q(flag_q)
    );

    mbx_status_bank u_stat (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .mgmt_wr(mgmt_wr),
        .stat_q(stat_q), .m_en_q(m_en_q), .h_en_q(h_en_q)
    );

    // Host-owned doorbell byte, rung by management sends.
    mbx_doorbell u_hdoor (
        .clk(clk), .rst_n(rst_n),
        .own_wr_i(h_we && h_addr == OFF_HCTL),
        .own_clr_i(h_wdata[CTL_PEND]),
        .own_mask_i(h_wdata[CTL_MASK]),
        .ring_i(m_we && m_addr == OFF_MCTL && m_wdata[CTL_SEND]),
        .ctl_o(h_ctl_q), .irq_o(h_door_irq)
    );

    // Management-owned doorbell byte, rung by host sends.
    mbx_doorbell u_mdoor (
        .clk(clk), .rst_n(rst_n),
        .own_wr_i(m_we && m_addr == OFF_MCTL),
        .own_clr_i(m_wdata[CTL_PEND]),
        .own_mask_i(m_wdata[CTL_MASK]),
        .ring_i(h_we && h_addr == OFF_HCTL && h_wdata[CTL_SEND]),
        .ctl_o(m_ctl_q), .irq_o(m_door_irq)
    );

    assign h_irq = h_door_irq | (|(stat_q & h_en_q));
    assign m_irq = m_door_irq;

    logic [1:0][ADDR_W-1:0] rd_addr;
    logic [1:0][BYTE_W-1:0] rd_data;
    assign rd_addr[0] = h_addr;
    assign rd_addr[1] = m_addr;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        // Read mux for one port; unmapped offsets return zero.
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < MSG_BYTES; i++)
                if (rd_addr[p] == ADDR_W'(i)) rd_data[p] = msg_q[i];
            for (int j = 0; j < STAT_BYTES; j++) begin
                if (rd_addr[p] == OFF_STAT0 + ADDR_W'(j)) rd_data[p] = stat_q[j*BYTE_W +: BYTE_W];
                if (rd_addr[p] == OFF_MEN0 + ADDR_W'(j))  rd_data[p] = m_en_q[j*BYTE_W +: BYTE_W];
                if (rd_addr[p] == OFF_HEN0 + ADDR_W'(j))  rd_data[p] = h_en_q[j*BYTE_W +: BYTE_W];
            end
            if (rd_addr[p] == OFF_FLAG) rd_data[p] = flag_q;
            if (rd_addr[p] == OFF_MCTL) rd_data[p] = m_ctl_q;
            if (rd_addr[p] == OFF_HCTL) rd_data[p] = h_ctl_q;
        end
    end

    assign h_rdata = rd_data[0];
    assign m_rdata = rd_data[1];
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
// Property checker for the mailbox bank, bound to the top module.
// Assumes write strobes are sampled at the rising clock edge.
module mbx_checker
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              h_we,
    input logic [ADDR_W-1:0] h_addr,
    input logic [BYTE_W-1:0] h_wdata,
    input logic              m_we,
    input logic [ADDR_W-1:0] m_addr,
    input logic [BYTE_W-1:0] m_wdata,
    input logic              h_irq,
    input logic              m_irq,
    input logic [BYTE_W-1:0] h_ctl,
    input logic [BYTE_W-1:0] m_ctl,
    input logic [BYTE_W-1:0] msg0,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] h_en
);
    // R2
    msg_mgmt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && m_addr == 5'h00) |=> (msg0 == $past(m_wdata)));
    // R2
    msg_host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == 5'h00 && !(m_we && m_addr == 5'h00)) |=> (msg0 == $past(h_wdata)));
    // R5
    host_rings_mgmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == OFF_HCTL && h_wdata[CTL_SEND]) |=> m_ctl[CTL_PEND]);
    // R5
    mgmt_rings_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_we && m_addr == OFF_MCTL && m_wdata[CTL_SEND]) |=> h_ctl[CTL_PEND]);
    // R6
    host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == OFF_HCTL && h_wdata[CTL_PEND] &&
         !(m_we && m_addr == OFF_MCTL && m_wdata[CTL_SEND])) |=> !h_ctl[CTL_PEND]);
    // R4
    attn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == OFF_STAT0 + 5'd1 && h_wdata[7] &&
         !(m_we && m_addr == OFF_STAT0 + 5'd1 && m_wdata[7])) |=> !stat[ATTN_BIT]);
    // R9
    host_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_ctl[CTL_PEND] && !h_ctl[CTL_MASK]) || (|(stat & h_en))) |-> h_irq);
    // R10
    mgmt_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_ctl[CTL_MASK] |-> !m_irq);
endmodule

bind dual_mailbox_regs mbx_checker chk (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .h_irq(h_irq), .m_irq(m_irq),
    .h_ctl(h_ctl_q), .m_ctl(m_ctl_q), .msg0(msg_q[0]),
    .stat(stat_q), .h_en(h_en_q)
);

// File: tb/tb_dual_mailbox_regs.sv
`timescale 1ns/1ps
// Self-checking bench: full address sweeps from both ports, collision
// sweeps and a doorbell/attention matrix, against a behavioural model.
module tb_dual_mailbox_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_we = 1'b0, m_we = 1'b0;
    logic [4:0] h_addr = '0, m_addr = '0;
    logic [7:0] h_wdata = '0, m_wdata = '0;
    logic [7:0] h_rdata, m_rdata;
    logic       h_irq, m_irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] mdl [32];

    always #2 clk = ~clk;

    dual_mailbox_regs dut (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .h_irq(h_irq), .m_irq(m_irq)
    );

    function automatic string tag_of(input int a);
        if (a < 14)  return "R2";
        if (a == 15) return "R3";
        if (a == 16 || a == 17) return "R4";
        if (a == 18 || a == 19) return "R5/R6/R7";
        if (a >= 20 && a <= 23) return "R8";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Model update for one cycle of (possibly simultaneous) writes.
    task automatic model_apply(input logic hv, input int ha, input logic [7:0] hd,
                               input logic mv, input int ma, input logic [7:0] md);
        logic [7:0] nx [32];
        for (int i = 0; i < 32; i++) nx[i] = mdl[i];
        if (mv && ma < 14) nx[ma] = md;
        if (hv && ha < 14 && !(mv && ma == ha)) nx[ha] = hd;
        if (mv && ma == 15) nx[15] = md;
        for (int j = 0; j < 2; j++) begin
            logic [7:0] clr, set;
            clr = (hv && ha == 16 + j) ? hd : 8'h00;
            set = (mv && ma == 16 + j) ? md : 8'h00;
            nx[16+j] = (mdl[16+j] & ~clr) | set;
        end
        if (mv && ma == 18) nx[18][1] = md[1];
        if (mv && ma == 18 && md[7]) nx[18][7] = 1'b0;
        if (hv && ha == 19 && hd[0]) nx[18][7] = 1'b1;
        if (hv && ha == 19) nx[19][1] = hd[1];
        if (hv && ha == 19 && hd[7]) nx[19][7] = 1'b0;
        if (mv && ma == 18 && md[0]) nx[19][7] = 1'b1;
        if (mv && (ma == 20 || ma == 21)) nx[ma] = md;
        if (hv && (ha == 22 || ha == 23)) nx[ha] = hd;
        for (int i = 0; i < 32; i++) mdl[i] = nx[i];
    endtask

    task automatic do_wr(input logic hv, input int ha, input logic [7:0] hd,
                         input logic mv, input int ma, input logic [7:0] md);
        @(negedge clk);
        h_we = hv; h_addr = 5'(ha); h_wdata = hd;
        m_we = mv; m_addr = 5'(ma); m_wdata = md;
        @(posedge clk);
        #1;
        h_we = 1'b0; m_we = 1'b0;
        model_apply(hv, ha, hd, mv, ma, md);
    endtask

    // Read every offset from both ports and compare both interrupts.
    task automatic check_all(input string phase);
        logic exp_h, exp_m;
        for (int a = 0; a < 32; a++) begin
            h_addr = 5'(a); m_addr = 5'(a);
            #0.5;
            check({phase, " ", tag_of(a), " host read"}, h_rdata, mdl[a]);
            check({phase, " ", tag_of(a), " mgmt read"}, m_rdata, mdl[a]);
        end
        exp_h = (mdl[19][7] && !mdl[19][1]) || (|(mdl[16] & mdl[22])) || (|(mdl[17] & mdl[23]));
        exp_m = mdl[18][7] && !mdl[18][1];
        check({phase, " R9 host irq"}, {7'b0, h_irq}, {7'b0, exp_h});
        check({phase, " R10 mgmt irq"}, {7'b0, m_irq}, {7'b0, exp_m});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of every offset and both interrupts
        check_all("R1 reset");

        // Host-only write sweep over the whole window (R3 ignored host flag write, R11 holes)
        for (int a = 0; a < 32; a++) begin
            do_wr(1'b1, a, 8'(a * 37 + 5), 1'b0, 0, 8'h00);
            check_all("host sweep");
        end
        // Management-only write sweep over the whole window
        for (int a = 0; a < 32; a++) begin
            do_wr(1'b0, 0, 8'h00, 1'b1, a, ~8'(a * 53 + 1));
            check_all("mgmt sweep");
        end
        // Same-offset collisions: management wins (R2), set wins (R4)
        for (int a = 0; a < 24; a++) begin
            do_wr(1'b1, a, 8'h5A ^ 8'(a), 1'b1, a, 8'hA5 + 8'(a));
            check_all("collision");
        end

        // R5 directed: host send while management clears and masks its own byte
        do_wr(1'b1, 19, 8'h01, 1'b1, 18, 8'h82);
        check_all("R5 ring beats clear");
        // R7: management unmasks without clearing; send bit reads back zero
        do_wr(1'b0, 0, 8'h00, 1'b1, 18, 8'h7D);
        check_all("R7 mask and reserved bits");

        // Doorbell / attention matrix (R4, R5, R6, R9, R10)
        for (int v = 0; v < 64; v++) begin
            do_wr(1'b1, 19, {v[4], 5'b0, v[0], 1'b0}, 1'b1, 18, {6'b0, v[5], v[3]});
            check_all("matrix ctl");
            do_wr(1'b1, 23, {v[2], 7'b0}, 1'b1, 17, {v[1], 7'b0});
            check_all("matrix attn");
            do_wr(1'b1, 17, {v[5], 7'b0}, 1'b0, 0, 8'h00);
            check_all("matrix attn clear");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule